// File: doc/BRIEF.md
# Half-Band Rate-Change FIR Filter

This block is a fixed-coefficient, linear-phase FIR filter with 55 effective taps. The coefficients are symmetric and half-band: every tap at an even, nonzero distance from the centre is zero. The two taps at each odd distance are summed before the multiply, so the filter needs fifteen multipliers. These are fourteen pre-added pairs and the centre tap. A pipelined multiply-accumulate with alignment stages follows the multipliers. The delay from any captured sample to the output it produces is fixed at seven clocks.

The filter has three rate modes. It can filter every clock at equal rate. It can decimate 2:1, where a sample is captured every clock but only every second filtered result is presented. It can interpolate 1:2, where a sample is accepted on alternate clocks and a zero is pushed into the tap line on the other clocks. The phase of the interpolation is set by a sync strobe. Interpolation comes in two gains: the plain zero-stuffed result (-6 dB) or that result doubled (0 dB). The output is the full-precision sum, which cannot overflow. A valid strobe marks each clock that presents a new result.

Top module: `hbf_fir`

## Requirements
- R1: While `rst` is high, and after the clock edge that sees it, `dout` is 0 and `dout_vld` is 0. After `rst` falls, `dout_vld` stays low until the seventh clock edge has passed.
- R2: Coefficient h[27] is 512. For tap offsets d = j-27 of ±1, ±3, ... ±27, the values are 307, -96, 50, -30, 19, -12, 8, -5, 3, -2, 1, -1, 1, -1, and h[27+d] = h[27-d]. Every other tap is zero.
- R3: With `mode_sel`=0 (equal rate), `din` is captured on every edge. Number the edges after reset from 1. After edge n+7, `dout` equals the sum over j of h[j]·s[n-j], where s[k] is the value pushed on edge k and s is 0 before edge 1. `dout_vld` is high on every clock from edge 8 on.
- R4: An impulse captured on edge n gives its first nonzero output after edge n+7, its peak after edge n+34, and its last nonzero output after edge n+61.
- R5: With `mode_sel`=1 (decimate), `din` is pushed on every edge. A result is presented only for samples captured on even-numbered edges after reset. Consequently, `dout_vld` is never high on two clocks in a row.
- R6: In decimation, `sync_in` has no effect. Holding it low and toggling it every clock give identical output sequences.
- R7: On any clock where `dout_vld` is low, `dout` keeps its previous value.
- R8: With `mode_sel`=2 or 3 (interpolate), an edge that sees `sync_in` high pushes a zero and arms the phase. The first edge with `sync_in` low pushes `din`. Each following edge with `sync_in` low alternates between pushing a zero and pushing `din`. The value of `din` on a zero edge is ignored.
- R9: With `mode_sel`=2, the interpolated output is the R3 sum. With `mode_sel`=3, it is twice that sum. `dout_vld` is high on every clock from edge 8 on in both modes.
- R10: For any signed 10-bit input sequence, including runs at -512 and +511 matched to the coefficient signs, `dout` (27-bit signed) equals the exact sum with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | 0 equal rate, 1 decimate, 2 interpolate -6 dB, 3 interpolate 0 dB |
| sync_in | input | 1 | Interpolation phase strobe |
| din | input | 10 | Signed two's complement input sample |
| dout | output | 27 | Full-precision signed filter result |
| dout_vld | output | 1 | High on each clock presenting a new result |

## Verification
The case hardest to reach from the ports is the worst-case accumulation. To hit it, all 55 taps must at once hold a full-scale sample whose sign matches its coefficient. The bench gets there by feeding, one per clock, the sign-matched sequence -512/+511 computed from its own coefficient list, then checking the peak output exactly. Two further situations need deliberate timing. One is a sync pulse dropped into a running interpolation stream, which re-phases the zero stuffing. The other is a pair of decimation runs that differ only in sync activity, whose recorded outputs are compared against each other.

// File: rtl/hbf_pkg.sv
package hbf_pkg;

  localparam int TAPS        = 55;
  localparam int CTR         = (TAPS - 1) / 2;
  localparam int NPAIR       = (CTR + 1) / 2;
  localparam int NTERM       = NPAIR + 1;
  localparam int CENTER_COEF = 512;

  typedef enum logic [1:0] {
    MODE_EQUAL      = 2'd0,
    MODE_DECIM      = 2'd1,
    MODE_INTRP_HALF = 2'd2,
    MODE_INTRP_FULL = 2'd3
  } rate_mode_e;

  // Coefficient of the tap pair at odd distance 2*m-1 from the centre.
  function automatic int side_coef(input int m);
    case (m)
      1:  side_coef = 307;
      2:  side_coef = -96;
      3:  side_coef = 50;
      4:  side_coef = -30;
      5:  side_coef = 19;
      6:  side_coef = -12;
      7:  side_coef = 8;
      8:  side_coef = -5;
      9:  side_coef = 3;
      10: side_coef = -2;
      11: side_coef = 1;
      12: side_coef = -1;
      13: side_coef = 1;
      14: side_coef = -1;
      default: side_coef = 0;
    endcase
  endfunction

endpackage

// File: rtl/hbf_rate_ctrl.sv
module hbf_rate_ctrl
  import hbf_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  rate_mode_e           mode,
  input  logic                 sync_in,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] push_data,
  output logic                 push_keep
);

  logic dec_ph;
  logic int_odd;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_ph  <= 1'b0;
      int_odd <= 1'b0;
    end else begin
      dec_ph <= ~dec_ph;
      if (sync_in) int_odd <= 1'b0;
      else         int_odd <= ~int_odd;
    end
  end

  always_comb begin
    unique case (mode)
      MODE_EQUAL: begin
        push_data = din;
        push_keep = 1'b1;
      end
      MODE_DECIM: begin
        push_data = din;
        push_keep = dec_ph;
      end
      default: begin
        push_data = (sync_in || int_odd) ? '0 : din;
        push_keep = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/hbf_tapline.sv
module hbf_tapline
  import hbf_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] push_data,
  input  logic                 push_keep,
  output logic signed [DW-1:0] tap_q [TAPS],
  output logic                 tag_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) tap_q[i] <= '0;
      tag_q <= 1'b0;
    end else begin
      tap_q[0] <= push_data;
      for (int i = 1; i < TAPS; i++) tap_q[i] <= tap_q[i-1];
      tag_q <= push_keep;
    end
  end

endmodule

// File: rtl/hbf_mac.sv
module hbf_mac
  import hbf_pkg::*;
#(
  parameter  int DW      = 10,
  parameter  int CW      = 11,
  parameter  int GRP     = 4,
  parameter  int OUT_LAT = 7,
  localparam int PW      = DW + 1,
  localparam int MW      = PW + CW,
  localparam int SW      = MW + $clog2(NTERM)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] tap_q [TAPS],
  input  logic                 tag_in,
  output logic signed [SW-1:0] acc,
  output logic                 acc_tag
);

  localparam int NGRP  = (NTERM + GRP - 1) / GRP;
  localparam int NPAD  = NGRP * GRP;
  localparam int ALIGN = OUT_LAT - 5;
  localparam int TD    = OUT_LAT - 1;

  logic signed [PW-1:0] pre_w  [NTERM];
  logic signed [MW-1:0] prod_w [NPAD];
  logic signed [SW-1:0] grp_w  [NGRP];
  logic signed [SW-1:0] total;
  logic signed [SW-1:0] sum_q;
  logic [TD-1:0]        tag_sr;

  // Stage 1: symmetric pre-add of each nonzero pair, centre passed alone.
  for (genvar m = 0; m < NPAIR; m++) begin : g_pair
    localparam int DIST = 2 * m + 1;
    logic signed [PW-1:0] pre_q;
    always_ff @(posedge clk) begin
      if (rst) pre_q <= '0;
      else     pre_q <= PW'(tap_q[CTR-DIST]) + PW'(tap_q[CTR+DIST]);
    end
    assign pre_w[m] = pre_q;
  end

  logic signed [PW-1:0] ctr_q;
  always_ff @(posedge clk) begin
    if (rst) ctr_q <= '0;
    else     ctr_q <= PW'(tap_q[CTR]);
  end
  assign pre_w[NPAIR] = ctr_q;

  // Stage 2: constant multiplies, padded to a whole number of groups.
  for (genvar i = 0; i < NPAD; i++) begin : g_mul
    if (i < NTERM) begin : g_live
      localparam logic signed [CW-1:0] K =
        CW'((i < NPAIR) ? side_coef(i + 1) : CENTER_COEF);
      logic signed [MW-1:0] p_q;
      always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= MW'(pre_w[i]) * MW'(K);
      end
      assign prod_w[i] = p_q;
    end else begin : g_pad
      assign prod_w[i] = '0;
    end
  end

  // Stage 3: partial sums per group.
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic signed [SW-1:0] part;
    logic signed [SW-1:0] part_q;
    always_comb begin
      part = '0;
      for (int i = 0; i < GRP; i++) part = part + SW'(prod_w[g*GRP+i]);
    end
    always_ff @(posedge clk) begin
      if (rst) part_q <= '0;
      else     part_q <= part;
    end
    assign grp_w[g] = part_q;
  end

  // Stage 4: final sum.
  always_comb begin
    total = '0;
    for (int g = 0; g < NGRP; g++) total = total + grp_w[g];
  end

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= total;
  end

  // Alignment stages pad the datapath up to the fixed latency.
  if (ALIGN == 0) begin : g_noalign
    assign acc = sum_q;
  end else begin : g_align
    logic signed [SW-1:0] al_q [ALIGN];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < ALIGN; i++) al_q[i] <= '0;
      end else begin
        al_q[0] <= sum_q;
        for (int i = 1; i < ALIGN; i++) al_q[i] <= al_q[i-1];
      end
    end
    assign acc = al_q[ALIGN-1];
  end

  // The valid tag rides alongside the data through every stage.
  always_ff @(posedge clk) begin
    if (rst) tag_sr <= '0;
    else     tag_sr <= {tag_sr[TD-2:0], tag_in};
  end
  assign acc_tag = tag_sr[TD-1];

endmodule

// File: rtl/hbf_fir.sv
module hbf_fir
  import hbf_pkg::*;
#(
  parameter  int DW      = 10,
  parameter  int CW      = 11,
  parameter  int GRP     = 4,
  parameter  int OUT_LAT = 7,
  localparam int SW      = DW + 1 + CW + $clog2(NTERM),
  localparam int OW      = SW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode_sel,
  input  logic                 sync_in,
  input  logic signed [DW-1:0] din,
  output logic signed [OW-1:0] dout,
  output logic                 dout_vld
);

  rate_mode_e           mode;
  logic signed [DW-1:0] push_data;
  logic                 push_keep;
  logic signed [DW-1:0] tap_q [TAPS];
  logic                 tag_q;
  logic signed [SW-1:0] acc;
  logic                 acc_tag;

  assign mode = rate_mode_e'(mode_sel);

  hbf_rate_ctrl #(.DW(DW)) u_rate (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .sync_in   (sync_in),
    .din       (din),
    .push_data (push_data),
    .push_keep (push_keep)
  );

  hbf_tapline #(.DW(DW)) u_taps (
    .clk       (clk),
    .rst       (rst),
    .push_data (push_data),
    .push_keep (push_keep),
    .tap_q     (tap_q),
    .tag_q     (tag_q)
  );

  hbf_mac #(.DW(DW), .CW(CW), .GRP(GRP), .OUT_LAT(OUT_LAT)) u_mac (
    .clk     (clk),
    .rst     (rst),
    .tap_q   (tap_q),
    .tag_in  (tag_q),
    .acc     (acc),
    .acc_tag (acc_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= acc_tag;
      if (acc_tag) begin
        if (mode == MODE_INTRP_FULL) dout <= OW'(acc) <<< 1;
        else                         dout <= OW'(acc);
      end
    end
  end

endmodule

// File: rtl/hbf_fir_chk.sv
module hbf_fir_chk #(
  parameter int OW = 27
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           mode_sel,
  input logic signed [OW-1:0] dout,
  input logic                 dout_vld
);

  logic [3:0] settle;
  logic [1:0] mode_q;
  logic       settled;

  always_ff @(posedge clk) begin
    if (rst) begin
      settle <= 4'd0;
      mode_q <= mode_sel;
    end else begin
      mode_q <= mode_sel;
      if (mode_sel != mode_q)  settle <= 4'd0;
      else if (settle != 4'hF) settle <= settle + 4'd1;
    end
  end

  assign settled = (settle >= 4'd8) && (mode_sel == mode_q);

  // R1: reset clears the outputs.
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!dout_vld && dout == '0));

  // R3 and R9: full-rate modes present a result every clock once filled.
  p_full_rate_r3: assert property (@(posedge clk) disable iff (rst)
    (settled && mode_sel != 2'd1) |-> dout_vld);

  // R5: decimated results never come on adjacent clocks.
  p_decim_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (settled && mode_sel == 2'd1 && dout_vld) |=> !dout_vld);

  // R7: the result holds while no new one is flagged.
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !dout_vld |-> $stable(dout));

endmodule

bind hbf_fir hbf_fir_chk #(.OW(OW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_sel (mode_sel),
  .dout     (dout),
  .dout_vld (dout_vld)
);

// File: tb/sim_hbf_fir.sv
`timescale 1ns/1ps
module sim_hbf_fir;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        mode_sel = 2'd0;
  logic              sync_in = 1'b0;
  logic signed [9:0] din = '0;
  logic signed [26:0] dout;
  logic              dout_vld;

  always #4 clk = ~clk;

  hbf_fir u0 (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .sync_in  (sync_in),
    .din      (din),
    .dout     (dout),
    .dout_vld (dout_vld)
  );

  int     vec = 0;
  int     bad = 0;
  bit     done = 1'b0;
  int     e;
  int     sv [0:4095];
  bit     kv [0:4095];
  bit     ph_m, odd_m;
  longint hold_m;
  logic [15:0] lfsr = 16'hACE1;
  longint rec_a [0:511];
  longint rec_b [0:511];
  int     na, nb;
  int     rec_sel;

  // R2: independent coefficient list.
  function automatic int h(input int j);
    int d, a;
    d = j - 27;
    a = (d < 0) ? -d : d;
    if (d == 0) return 512;
    if (a % 2 == 0) return 0;
    case ((a + 1) / 2)
      1: return 307;   2: return -96;  3: return 50;  4: return -30;
      5: return 19;    6: return -12;  7: return 8;   8: return -5;
      9: return 3;    10: return -2;  11: return 1;  12: return -1;
      13: return 1;   14: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic longint conv(input int n);
    longint s = 0;
    for (int j = 0; j < 55; j++)
      if (n - j >= 1) s += longint'(h(j)) * longint'(sv[n-j]);
    return s;
  endfunction

  function automatic int rnd10();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'($signed(lfsr[9:0]));
  endfunction

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; mode_sel = m; din = '0; sync_in = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    vec++;
    if (dout !== 27'sd0 || dout_vld !== 1'b0) begin
      bad++;
      $display("FAIL R1: dout=%0d vld=%0b expected dout=0 vld=0", dout, dout_vld);
    end
    @(negedge clk);
    rst = 1'b0;
    e = 0; ph_m = 1'b0; odd_m = 1'b0; hold_m = 0;
  endtask

  // Starts at a falling edge, ends at the next falling edge.
  task automatic step(input int x, input bit s, input string req_v, input string req_h);
    bit     ev;
    longint ed;
    int     g;
    din = 10'(x); sync_in = s;
    @(posedge clk);
    #1;
    e++;
    case (mode_sel)
      2'd0: begin sv[e] = x; kv[e] = 1'b1; end
      2'd1: begin sv[e] = x; kv[e] = ph_m; end
      default: begin
        sv[e] = (s || odd_m) ? 0 : x;
        kv[e] = 1'b1;
      end
    endcase
    ph_m  = ~ph_m;
    odd_m = s ? 1'b0 : ~odd_m;
    g = (mode_sel == 2'd3) ? 2 : 1;
    if (e >= 8 && kv[e-7]) begin
      ev = 1'b1; ed = g * conv(e - 7); hold_m = ed;
    end else begin
      ev = 1'b0; ed = hold_m;
    end
    vec++;
    if (dout_vld !== ev || longint'(dout) !== ed) begin
      bad++;
      $display("FAIL %s: dout=%0d vld=%0b expected dout=%0d vld=%0b at edge %0d",
               ev ? req_v : req_h, dout, dout_vld, ed, ev, e);
    end
    if (dout_vld === 1'b1) begin
      if (rec_sel == 1 && na < 512) begin rec_a[na] = longint'(dout); na++; end
      if (rec_sel == 2 && nb < 512) begin rec_b[nb] = longint'(dout); nb++; end
    end
    @(negedge clk);
  endtask

  initial begin
    int first_nz, last_nz, peak_e;
    longint peak_v, mag;
    rec_sel = 0; na = 0; nb = 0;

    // R1, R2, R4: impulse at equal rate.
    do_reset(2'd0);
    first_nz = -1; last_nz = -1; peak_e = -1; peak_v = 0;
    for (int i = 0; i < 75; i++) begin
      step((i == 0) ? 100 : 0, 1'b0, "R2", "R1");
      mag = (dout < 0) ? -longint'(dout) : longint'(dout);
      if (mag != 0) begin
        if (first_nz < 0) first_nz = e;
        last_nz = e;
        if (mag > peak_v) begin peak_v = mag; peak_e = e; end
      end
    end
    vec++;
    if (first_nz != 8 || peak_e != 35 || last_nz != 62) begin
      bad++;
      $display("FAIL R4: first=%0d peak=%0d last=%0d expected first=8 peak=35 last=62",
               first_nz, peak_e, last_nz);
    end

    // R3: equal rate, pseudo-random samples.
    do_reset(2'd0);
    for (int i = 0; i < 200; i++) step(rnd10(), i[0], "R3", "R3");

    // R10: sign-matched full-scale sequence, then constant extremes.
    do_reset(2'd0);
    for (int i = 0; i < 55; i++) step((h(54 - i) >= 0) ? 511 : -512, 1'b0, "R10", "R10");
    for (int i = 0; i < 60; i++) step(-512, 1'b0, "R10", "R10");
    for (int i = 0; i < 60; i++) step(511, 1'b0, "R10", "R10");
    for (int i = 0; i < 60; i++) step(0, 1'b0, "R10", "R10");

    // R5, R7: decimation with sync held low (recorded).
    lfsr = 16'h1D2B;
    do_reset(2'd1);
    rec_sel = 1;
    for (int i = 0; i < 160; i++) step(rnd10(), 1'b0, "R5", "R7");
    // R6: same samples with sync toggling every clock (recorded).
    lfsr = 16'h1D2B;
    do_reset(2'd1);
    rec_sel = 2;
    for (int i = 0; i < 160; i++) step(rnd10(), i[0], "R6", "R7");
    rec_sel = 0;
    vec++;
    if (na != nb || na == 0) begin
      bad++;
      $display("FAIL R6: record counts %0d expected %0d", nb, na);
    end else begin
      for (int i = 0; i < na; i++) begin
        vec++;
        if (rec_a[i] != rec_b[i]) begin
          bad++;
          $display("FAIL R6: output %0d = %0d expected %0d", i, rec_b[i], rec_a[i]);
        end
      end
    end

    // R8: interpolate -6 dB, one sync clock, junk on zero slots, mid-stream resync.
    do_reset(2'd2);
    step(0, 1'b1, "R8", "R8");
    for (int i = 0; i < 120; i++) step(rnd10(), 1'b0, "R8", "R8");
    step(rnd10(), 1'b1, "R8", "R8");
    for (int i = 0; i < 90; i++) step(rnd10(), 1'b0, "R8", "R8");

    // R9: interpolate 0 dB, three sync clocks, extremes and random.
    do_reset(2'd3);
    for (int i = 0; i < 3; i++) step(77, 1'b1, "R9", "R9");
    for (int i = 0; i < 60; i++) step(i[1] ? -512 : 511, 1'b0, "R9", "R9");
    for (int i = 0; i < 100; i++) step(rnd10(), 1'b0, "R9", "R9");
    step(5, 1'b1, "R9", "R9");
    step(5, 1'b1, "R9", "R9");
    for (int i = 0; i < 80; i++) step(rnd10(), 1'b0, "R9", "R9");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++;
      vec++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule